// File: doc/BRIEF.md
# Statistical DRAM Access Outcome Generator

This block settles, in one cycle, what a main-memory request would have cost in a statistical model of a multicore system. There is no real row-buffer state behind it. Each request carries a program ID, a physical address and a row stack depth. The block derives the bank from the address. It then compares the requester with the program that made the previous access. Bank-hit and row-hit flags come out of that comparison, and so does the latency picked by those two flags.

When the requester is the program that made the previous access, both flags are drawn from programmable probability tables. Each probability is compared against a slice of a free-running pseudo-random source. When a different program made the previous access, fixed rules apply. A bank hit needs the same bank as before, and a row hit is impossible.

The probability tables and the four latencies are loaded through one write port. The register map is described in R10. After every request, the bank and the owner are updated to those of the request.

Top module: `dram_outcome_model`

## Requirements
- R1: The bank index is `req_addr[BANK_LSB +: log2(BANKS)]`, which is bits 15:13 by default.
- R2: Reset has the following effects:
  - All probabilities and latencies are cleared to zero.
  - The active bank and the owner program are set to 0.
  - The random source is loaded with `SEED`.
  - `rsp_valid`, `rsp_bank_hit`, `rsp_row_hit` and `rsp_latency` go to 0.
- R3: The same-owner case is when `req_prog` equals the stored owner. In that case a bank hit occurs when the random state bits [15:0] are strictly less than the bank-hit probability of bank b.
- R4: In the same-owner case, a row hit occurs when the random state bits [31:16] are strictly less than the row-hit probability of (bank b, depth bucket).
- R5: The depth bucket equals `req_depth` when it is below BUCKETS-1. Any depth of BUCKETS-1 (15) or more maps to bucket BUCKETS-1.
- R6: When `req_prog` differs from the stored owner, a bank hit occurs exactly when b equals the active bank, and the row-hit flag is 0.
- R7: `rsp_latency` is the latency register indexed by {bank_hit, row_hit}. Index 3 means both flags hit and index 0 means neither does.
- R8: Each request updates three pieces of state:
  - The active bank becomes b.
  - The owner becomes `req_prog`.
  - The 32-bit random state shifts left by one, taking in bit 31^21^1^0 at bit 0.
  - A cycle with no request changes none of these.
- R9: The response appears on the cycle after the request, with `rsp_valid` high. In a cycle with no response, all response outputs are 0.
- R10: A write with `cfg_we` high is decoded from `cfg_addr`:
  - Bits [8:7] select the target.
    - 0 selects a bank probability, indexed by bits [2:0].
    - 1 selects a row probability, with the bank in bits [6:4] and the bucket in bits [3:0].
    - 2 selects a latency, indexed by bits [1:0].
    - 3 writes nothing.
  - A request in the same cycle as a write still sees the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_prog | input | PROG_W | Requesting program ID |
| req_addr | input | ADDR_W | Physical address |
| req_depth | input | DEPTH_W | Row stack depth |
| cfg_we | input | 1 | Table/latency write enable |
| cfg_addr | input | log2(BANKS)+log2(BUCKETS)+2 | Write target (see R10) |
| cfg_data | input | PROB_W | Write data; latencies use the low LAT_W bits |
| rsp_valid | output | 1 | Response valid |
| rsp_bank_hit | output | 1 | Bank-hit outcome |
| rsp_row_hit | output | 1 | Row-hit outcome |
| rsp_latency | output | LAT_W | Selected latency |

## Verification
The hardest case to reach is a program switch onto the bank that is still active. That is the only path giving a bank hit with a forced row miss. The stimulus first lets one program touch a bank, then issues a different program to the same bank with other address bits changed.

Probabilistic outcomes are reached by loading probabilities of 0 and 0xFFFF next to mid-range values, so that both results of the comparison occur. The bench tracks the random sequence itself, so every draw is predicted exactly. A write in the same cycle as a request that reads that entry is also driven on purpose.

// File: rtl/dom_pkg.sv
package dom_pkg;
   typedef enum logic [1:0] {
      CFG_BANK_P = 2'd0,
      CFG_ROW_P  = 2'd1,
      CFG_LAT    = 2'd2,
      CFG_NONE   = 2'd3
   } cfg_sel_e;

   // one step of the 32-bit maximal-length sequence (taps 32,22,2,1)
   function automatic logic [31:0] rng_advance(input logic [31:0] s);
      return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
   endfunction
endpackage

// File: rtl/dom_lfsr.sv
module dom_lfsr #(
   parameter logic [31:0] SEED = 32'h1D87_2B41
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        step,
   output logic [31:0] state
);
   import dom_pkg::*;

   if (SEED == 32'd0) begin : g_bad_seed
      $error("dom_lfsr: SEED must be non-zero");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    state <= SEED;
      else if (step) state <= rng_advance(state);
   end
endmodule

// File: rtl/dom_prob_store.sv
module dom_prob_store #(
   parameter int BANKS   = 8,
   parameter int BUCKETS = 16,
   parameter int PROB_W  = 16,
   parameter int LAT_W   = 12,
   localparam int BW     = $clog2(BANKS),
   localparam int KW     = $clog2(BUCKETS),
   localparam int IW     = BW + KW
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  dom_pkg::cfg_sel_e     sel,
   input  logic [IW-1:0]         idx,
   input  logic [PROB_W-1:0]     wdata,
   input  logic [BW-1:0]         rd_bank,
   input  logic [KW-1:0]         rd_bucket,
   output logic [PROB_W-1:0]     bank_p,
   output logic [PROB_W-1:0]     row_p,
   output logic [4*LAT_W-1:0]    lat_flat
);
   import dom_pkg::*;

   logic [BANKS*PROB_W-1:0]         bank_flat;
   logic [BANKS*BUCKETS*PROB_W-1:0] row_flat;

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic [PROB_W-1:0] bp_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) bp_q <= '0;
         else if (we && sel == CFG_BANK_P && idx[BW-1:0] == BW'(b)) bp_q <= wdata;
      end
      assign bank_flat[b*PROB_W +: PROB_W] = bp_q;

      for (genvar k = 0; k < BUCKETS; k++) begin : g_bucket
         logic [PROB_W-1:0] rp_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rp_q <= '0;
            else if (we && sel == CFG_ROW_P && idx == IW'(b*BUCKETS + k)) rp_q <= wdata;
         end
         assign row_flat[(b*BUCKETS + k)*PROB_W +: PROB_W] = rp_q;
      end
   end

   for (genvar i = 0; i < 4; i++) begin : g_lat
      logic [LAT_W-1:0] lat_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lat_q <= '0;
         else if (we && sel == CFG_LAT && idx[1:0] == 2'(i)) lat_q <= wdata[LAT_W-1:0];
      end
      assign lat_flat[i*LAT_W +: LAT_W] = lat_q;
   end

   assign bank_p = bank_flat[rd_bank*PROB_W +: PROB_W];
   assign row_p  = row_flat[{rd_bank, rd_bucket}*PROB_W +: PROB_W];
endmodule

// File: rtl/dom_outcome_logic.sv
module dom_outcome_logic #(
   parameter int BANKS  = 8,
   parameter int PROB_W = 16,
   localparam int BW    = $clog2(BANKS)
)(
   input  logic              same_owner,
   input  logic [BW-1:0]     bank,
   input  logic [BW-1:0]     active,
   input  logic [PROB_W-1:0] rnd_bank,
   input  logic [PROB_W-1:0] rnd_row,
   input  logic [PROB_W-1:0] p_bank,
   input  logic [PROB_W-1:0] p_row,
   output logic              bank_hit,
   output logic              row_hit
);
   always_comb begin
      if (same_owner) begin
         bank_hit = rnd_bank < p_bank;
         row_hit  = rnd_row  < p_row;
      end else begin
         bank_hit = (bank == active);
         row_hit  = 1'b0;
      end
   end
endmodule

// File: rtl/dram_outcome_model.sv
module dram_outcome_model #(
   parameter int          ADDR_W   = 32,
   parameter int          PROG_W   = 4,
   parameter int          DEPTH_W  = 8,
   parameter int          BANKS    = 8,
   parameter int          BUCKETS  = 16,
   parameter int          BANK_LSB = 13,
   parameter int          PROB_W   = 16,
   parameter int          LAT_W    = 12,
   parameter logic [31:0] SEED     = 32'h1D87_2B41
)(
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic                                       req_valid,
   input  logic [PROG_W-1:0]                          req_prog,
   input  logic [ADDR_W-1:0]                          req_addr,
   input  logic [DEPTH_W-1:0]                         req_depth,
   input  logic                                       cfg_we,
   input  logic [$clog2(BANKS)+$clog2(BUCKETS)+1:0]   cfg_addr,
   input  logic [PROB_W-1:0]                          cfg_data,
   output logic                                       rsp_valid,
   output logic                                       rsp_bank_hit,
   output logic                                       rsp_row_hit,
   output logic [LAT_W-1:0]                           rsp_latency
);
   import dom_pkg::*;

   localparam int BW = $clog2(BANKS);
   localparam int KW = $clog2(BUCKETS);
   localparam int IW = BW + KW;

   if ((1 << BW) != BANKS || BANKS < 2)       begin : g_chk_banks   $error("BANKS must be a power of two >= 2");   end
   if ((1 << KW) != BUCKETS || BUCKETS < 2)   begin : g_chk_buckets $error("BUCKETS must be a power of two >= 2"); end
   if (PROB_W > 16 || PROB_W < 2)             begin : g_chk_prob    $error("PROB_W must fit a 16-bit random slice"); end
   if (LAT_W > PROB_W)                        begin : g_chk_lat     $error("LAT_W must not exceed PROB_W");        end
   if (DEPTH_W < KW)                          begin : g_chk_depth   $error("DEPTH_W narrower than bucket index");  end
   if (BANK_LSB + BW > ADDR_W)                begin : g_chk_addr    $error("bank field outside the address");      end

   logic [BW-1:0]     req_bank;
   logic [KW-1:0]     req_bucket;
   logic [BW-1:0]     active_q;
   logic [PROG_W-1:0] owner_q;
   logic [31:0]       rnd;
   logic [PROB_W-1:0] p_bank, p_row;
   logic [4*LAT_W-1:0] lat_flat;
   logic              bank_hit, row_hit;
   logic [1:0]        lat_idx;
   cfg_sel_e          cfg_sel;

   assign req_bank   = req_addr[BANK_LSB +: BW];
   assign req_bucket = (req_depth >= DEPTH_W'(BUCKETS - 1)) ? KW'(BUCKETS - 1) : req_depth[KW-1:0];
   assign cfg_sel    = cfg_sel_e'(cfg_addr[IW+1 -: 2]);

   dom_lfsr #(.SEED(SEED)) u_rng (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (req_valid),
      .state (rnd)
   );

   dom_prob_store #(
      .BANKS(BANKS), .BUCKETS(BUCKETS), .PROB_W(PROB_W), .LAT_W(LAT_W)
   ) u_tables (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (cfg_we),
      .sel       (cfg_sel),
      .idx       (cfg_addr[IW-1:0]),
      .wdata     (cfg_data),
      .rd_bank   (req_bank),
      .rd_bucket (req_bucket),
      .bank_p    (p_bank),
      .row_p     (p_row),
      .lat_flat  (lat_flat)
   );

   dom_outcome_logic #(.BANKS(BANKS), .PROB_W(PROB_W)) u_decide (
      .same_owner (req_prog == owner_q),
      .bank       (req_bank),
      .active     (active_q),
      .rnd_bank   (rnd[PROB_W-1:0]),
      .rnd_row    (rnd[16 +: PROB_W]),
      .p_bank     (p_bank),
      .p_row      (p_row),
      .bank_hit   (bank_hit),
      .row_hit    (row_hit)
   );

   assign lat_idx = {bank_hit, row_hit};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q     <= '0;
         owner_q      <= '0;
         rsp_valid    <= 1'b0;
         rsp_bank_hit <= 1'b0;
         rsp_row_hit  <= 1'b0;
         rsp_latency  <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_bank_hit <= bank_hit;
            rsp_row_hit  <= row_hit;
            rsp_latency  <= lat_flat[lat_idx*LAT_W +: LAT_W];
            active_q     <= req_bank;
            owner_q      <= req_prog;
         end else begin
            rsp_bank_hit <= 1'b0;
            rsp_row_hit  <= 1'b0;
            rsp_latency  <= '0;
         end
      end
   end
endmodule

// File: rtl/dom_outcome_checks.sv
module dom_outcome_checks #(
   parameter int PROG_W = 4,
   parameter int BW     = 3,
   parameter int LAT_W  = 12
)(
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [PROG_W-1:0] req_prog,
   input logic [BW-1:0]     req_bank,
   input logic [BW-1:0]     active_q,
   input logic [PROG_W-1:0] owner_q,
   input logic              rsp_valid,
   input logic              rsp_bank_hit,
   input logic              rsp_row_hit,
   input logic [LAT_W-1:0]  rsp_latency
);
   p_resp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   p_no_spurious_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (!rsp_bank_hit && !rsp_row_hit && rsp_latency == '0));

   p_foreign_row_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_prog != owner_q) |=> !rsp_row_hit);

   p_foreign_bank_rule_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_prog != owner_q) |=> (rsp_bank_hit == $past(req_bank == active_q)));

   p_owner_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (owner_q == $past(req_prog) && active_q == $past(req_bank)));

   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(owner_q) && $stable(active_q)));
endmodule

bind dram_outcome_model dom_outcome_checks #(
   .PROG_W(PROG_W), .BW($clog2(BANKS)), .LAT_W(LAT_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_prog     (req_prog),
   .req_bank     (req_bank),
   .active_q     (active_q),
   .owner_q      (owner_q),
   .rsp_valid    (rsp_valid),
   .rsp_bank_hit (rsp_bank_hit),
   .rsp_row_hit  (rsp_row_hit),
   .rsp_latency  (rsp_latency)
);

// File: tb/dram_outcome_model_bench.sv
module dram_outcome_model_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic [3:0]  req_prog;
   logic [31:0] req_addr;
   logic [7:0]  req_depth;
   logic        cfg_we;
   logic [8:0]  cfg_addr;
   logic [15:0] cfg_data;
   logic        rsp_valid, rsp_bank_hit, rsp_row_hit;
   logic [11:0] rsp_latency;

   always #10 clk = ~clk;

   dram_outcome_model u_dram_outcome_model (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_prog(req_prog),
      .req_addr(req_addr), .req_depth(req_depth), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_data(cfg_data), .rsp_valid(rsp_valid),
      .rsp_bank_hit(rsp_bank_hit), .rsp_row_hit(rsp_row_hit), .rsp_latency(rsp_latency)
   );

   int total = 0;
   int bad   = 0;

   // reference state
   logic [31:0] m_rng;
   int          m_bp [8];
   int          m_rp [8][16];
   int          m_lat[4];
   int          m_act, m_own;
   // expected response
   bit    e_v, e_bh, e_rh;
   int    e_lat;
   string e_tb, e_tr, e_tl;

   task automatic check(string tag, longint act, longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_rng = 32'h1D87_2B41;
      for (int i = 0; i < 8; i++) begin
         m_bp[i] = 0;
         for (int k = 0; k < 16; k++) m_rp[i][k] = 0;
      end
      for (int i = 0; i < 4; i++) m_lat[i] = 0;
      m_act = 0; m_own = 0;
      e_v = 0; e_bh = 0; e_rh = 0; e_lat = 0;
      e_tb = "R9"; e_tr = "R9"; e_tl = "R9";
   endtask

   // one clock: compare last response, drive new inputs, advance model
   task automatic step(bit v, int prog, logic [31:0] addr, int depth,
                       bit we, int wa, int wd, string note);
      int b, bk, rb, rr;
      @(negedge clk);
      check({"R9 valid"}, rsp_valid, e_v);
      check({e_tb, " bank_hit"}, rsp_bank_hit, e_bh);
      check({e_tr, " row_hit"}, rsp_row_hit, e_rh);
      check({e_tl, " latency"}, rsp_latency, e_lat);
      req_valid = v; req_prog = prog[3:0]; req_addr = addr; req_depth = depth[7:0];
      cfg_we = we; cfg_addr = wa[8:0]; cfg_data = wd[15:0];
      if (v) begin
         b  = int'(addr[15:13]);
         bk = (depth >= 15) ? 15 : depth;
         rb = int'(m_rng[15:0]);
         rr = int'(m_rng[31:16]);
         if (prog == m_own) begin
            e_bh = rb < m_bp[b];
            e_rh = rr < m_rp[b][bk];
            e_tb = {"R3 ", note}; e_tr = {"R4 ", note};
         end else begin
            e_bh = (b == m_act);
            e_rh = 0;
            e_tb = {"R6 ", note}; e_tr = {"R6 ", note};
         end
         e_lat = m_lat[e_bh * 2 + e_rh];
         e_tl  = {"R7 ", note};
         e_v   = 1;
         m_act = b; m_own = prog;
         m_rng = {m_rng[30:0], ^(m_rng & 32'h8020_0003)};
      end else begin
         e_v = 0; e_bh = 0; e_rh = 0; e_lat = 0;
         e_tb = "R9"; e_tr = "R9"; e_tl = "R9";
      end
      if (we) begin
         case (wa >> 7)
            0: m_bp[wa & 7] = wd & 16'hFFFF;
            1: m_rp[(wa >> 4) & 7][wa & 15] = wd & 16'hFFFF;
            2: m_lat[wa & 3] = wd & 12'hFFF;
            default: ;
         endcase
      end
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, "");
   endtask

   task automatic wr(int wa, int wd);
      step(0, 0, 0, 0, 1, wa, wd, "R10");
   endtask

   function automatic logic [31:0] addr_of(int bank, logic [31:0] noise);
      return (noise & ~32'h0000_E000) | (32'(bank) << 13);
   endfunction

   initial begin
      #(20 * 200000);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 0; req_valid = 0; req_prog = 0; req_addr = 0; req_depth = 0;
      cfg_we = 0; cfg_addr = 0; cfg_data = 0;
      model_reset();
      repeat (3) @(negedge clk);
      // R2: outputs cleared in reset
      check("R2 valid", rsp_valid, 0);
      check("R2 bank_hit", rsp_bank_hit, 0);
      check("R2 row_hit", rsp_row_hit, 0);
      check("R2 latency", rsp_latency, 0);
      rst_n = 1;

      // R2: zero tables, owner 0 -> same-owner path never hits, latency 0
      step(1, 0, addr_of(4, 32'h1234_5678), 3, 0, 0, 0, "R2");
      idle(1);

      // load latencies, bank and row probabilities (R10)
      wr((2 << 7) | 0, 100);
      wr((2 << 7) | 1, 60);
      wr((2 << 7) | 2, 40);
      wr((2 << 7) | 3, 20);
      for (int b = 0; b < 8; b++)
         wr(b, (b == 0) ? 16'hFFFF : (b == 1) ? 0 : b * 16'h2000);
      for (int b = 0; b < 8; b++)
         for (int k = 0; k < 16; k++)
            wr((1 << 7) | (b << 4) | k,
               (b == 3) ? ((k == 15) ? 16'hFFFF : 0) : ((b * 16 + k) * 509) & 16'hFFFF);

      // R1/R6: program 2 opens bank 5, program 3 hits bank 5 with other address bits
      step(1, 2, addr_of(5, 32'h0000_0010), 0, 0, 0, 0, "R1");
      step(1, 3, addr_of(5, 32'hFFFF_1FFF), 0, 0, 0, 0, "R1");
      step(1, 2, addr_of(6, 32'h0), 0, 0, 0, 0, "R6");
      idle(1);

      // R8: owner/bank follow requests; idle cycles keep them
      step(1, 4, addr_of(2, 32'h0), 1, 0, 0, 0, "R8");
      step(1, 4, addr_of(6, 32'h0), 1, 0, 0, 0, "R8");
      idle(3);
      step(1, 5, addr_of(6, 32'h40), 2, 0, 0, 0, "R8");
      step(1, 5, addr_of(1, 32'h80), 2, 0, 0, 0, "R8");
      step(1, 5, addr_of(0, 32'h80), 2, 0, 0, 0, "R8");

      // R5: bucket clamp on bank 3 (only bucket 15 has probability)
      step(1, 7, addr_of(3, 32'h0), 0, 0, 0, 0, "R5");
      step(1, 7, addr_of(3, 32'h0), 14, 0, 0, 0, "R5");
      step(1, 7, addr_of(3, 32'h0), 15, 0, 0, 0, "R5");
      step(1, 7, addr_of(3, 32'h0), 200, 0, 0, 0, "R5");
      step(1, 7, addr_of(3, 32'h0), 255, 0, 0, 0, "R5");

      // R10: write in same cycle as a request reading it sees old value
      step(1, 7, addr_of(3, 32'h0), 99, 1, (1 << 7) | (3 << 4) | 15, 0, "R10");
      step(1, 7, addr_of(3, 32'h0), 99, 0, 0, 0, "R10");
      step(1, 7, addr_of(0, 32'h0), 0, 1, 0, 0, "R10");
      step(1, 7, addr_of(0, 32'h0), 0, 1, (3 << 7) | 5, 16'hFFFF, "R10");
      step(1, 7, addr_of(5, 32'h0), 0, 0, 0, 0, "R10");

      // mixed random traffic (R3, R4, R6, R7, R9)
      for (int n = 0; n < 3000; n++) begin
         int sel;
         sel = int'($urandom_range(0, 99));
         step(sel < 75, int'($urandom_range(0, 3)), $urandom(), int'($urandom_range(0, 31)),
              sel > 88, int'($urandom_range(0, 383)), int'($urandom_range(0, 65535)), "mix");
      end
      idle(2);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule